// File: doc/BRIEF.md
# UART Register and Interrupt Unit

This block is the register-side half of a simple serial port with a fixed frame of eight data bits, no parity and one stop bit. It sits on an APB bus and holds one byte waiting to be sent, one byte that has arrived, a set of status flags, a control register of enables, and a 20-bit baud divisor. A separate serial engine, which is not part of this block, connects on the line side. That engine takes a byte through a valid/accept handshake, delivers each received byte with a one-cycle strobe, and reads the divisor together with a flag that says whether the divisor may be used.

Software writes a byte to the data register to send it and reads the same register to collect a received byte. It watches the full and overrun flags and clears overrun conditions by writing ones. Four individual interrupt lines report a byte sent, a byte received, a transmit overrun and a receive overrun. A fifth line is the OR of those four. The two overrun interrupt bits are not stored: each one is always the overrun flag ANDed with its enable. Clearing either of them clears the flag underneath. A block of read-only identification words sits at the top of the 4 KiB window.

Top module: `uart_regif`

## Requirements
- R1: After reset, every register reads zero (status 0x04, control 0x08, interrupt status 0x0C, divisor 0x10, data 0x00), `tx_valid` is low and all interrupt lines are low.
- R2: A write to the data offset 0x00 while the transmit-full flag (status bit 0) is clear stores the low byte and sets that flag. The byte then appears on `tx_byte` with `tx_valid` high, provided the transmit-enable bit is set and the divisor is valid.
- R3: A write to the data offset while status bit 0 is already set sets the transmit-overrun flag (status bit 2). The byte already held stays on `tx_byte` unchanged.
- R4: A cycle with `tx_valid` and `tx_accept` both high clears status bit 0. This transition sets interrupt status bit 0 only if control bit 2 (transmit interrupt enable) is set.
- R5: `tx_valid` is high only while control bit 0 (transmit enable) is set and the divisor is at least 16. A held byte survives while either condition is false, and status bit 0 stays set.
- R6: A `rx_strobe` is ignored while control bit 1 (receive enable) is clear. Otherwise the byte is stored and status bit 1 (receive full) is set. If bit 1 was already set, status bit 3 (receive overrun) is also set and the new byte replaces the old one. Interrupt status bit 1 is set when control bit 3 is set.
- R7: A read of the data offset returns the stored receive byte and clears status bit 1.
- R8: Status bits 0 and 1 ignore writes. Writing a one to status bit 2 or bit 3 clears that flag.
- R9: Interrupt status bits 2 and 3 equal status bits 2 and 3 ANDed with control bits 4 and 5. Writing ones to interrupt status clears the matching stored bits 0 and 1, and writing one to bit 2 or 3 clears the matching overrun flag.
- R10: `irq_tx`, `irq_rx`, `irq_tx_ovr` and `irq_rx_ovr` follow interrupt status bits 0 to 3. `irq_any` is their OR.
- R11: The control register keeps only bits 6:0. The divisor register keeps only bits 19:0. `baud_div_ok` is high only when the divisor is 16 or more.
- R12: Word offsets 0xFD0 to 0xFFC read, in address order, 0x04, 0x00, 0x00, 0x00, 0x21, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to these offsets are ignored.
- R13: Unmapped offsets read zero and ignore writes. `pready` is always high and `pslverr` always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high, zero wait states |
| pslverr | output | 1 | Always low |
| tx_byte | output | 8 | Byte held for sending |
| tx_valid | output | 1 | Held byte offered to the serial engine |
| tx_accept | input | 1 | Serial engine takes the offered byte |
| rx_byte | input | 8 | Received byte |
| rx_strobe | input | 1 | One-cycle pulse, `rx_byte` valid |
| baud_div | output | 20 | Programmed divisor |
| baud_div_ok | output | 1 | Divisor is usable (16 or more) |
| irq_tx | output | 1 | Byte-sent interrupt |
| irq_rx | output | 1 | Byte-received interrupt |
| irq_tx_ovr | output | 1 | Transmit overrun interrupt |
| irq_rx_ovr | output | 1 | Receive overrun interrupt |
| irq_any | output | 1 | OR of the four interrupts |

## Verification
The transmit path is tested four ways: with an invalid divisor, with a valid one, with the enable dropped while a byte is held, and with a second write before the first byte is taken. Together these separate gating, holding and overrun. The transmit handshake runs once with its interrupt enable set and once with it clear, which shows that the byte-sent bit depends on the enable. The receive path gets a strobe while disabled, a first byte and a second byte before any read. This separates dropping, storing and overrun-with-replacement. Write-one-to-clear is tried with ones on read-only bits, on a stored interrupt bit and on a live overrun interrupt bit, so that clearing through either register can be told apart.

// File: rtl/uart_regif_pkg.sv
// Package: shared offsets, register select codes, control bit positions and
// the identification word table for the UART register unit.
package uart_regif_pkg;

    // Word indices (byte offset >> 2) of the mapped registers.
    localparam int unsigned WIDX_DATA     = 0;
    localparam int unsigned WIDX_STATUS   = 1;
    localparam int unsigned WIDX_CONTROL  = 2;
    localparam int unsigned WIDX_INTSTAT  = 3;
    localparam int unsigned WIDX_DIVISOR  = 4;
    localparam int unsigned WIDX_ID_FIRST = 'h3F4;
    localparam int unsigned WIDX_ID_LAST  = 'h3FF;
    localparam int unsigned ID_COUNT      = WIDX_ID_LAST - WIDX_ID_FIRST + 1;

    // Control register bit positions.
    localparam int unsigned CB_TX_EN   = 0;
    localparam int unsigned CB_RX_EN   = 1;
    localparam int unsigned CB_TX_IE   = 2;
    localparam int unsigned CB_RX_IE   = 3;
    localparam int unsigned CB_TXO_IE  = 4;
    localparam int unsigned CB_RXO_IE  = 5;

    // Status / interrupt status bit positions.
    localparam int unsigned SB_TX_FULL = 0;
    localparam int unsigned SB_RX_FULL = 1;
    localparam int unsigned SB_TX_OVR  = 2;
    localparam int unsigned SB_RX_OVR  = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_STATUS,
        SEL_CONTROL,
        SEL_INTSTAT,
        SEL_DIVISOR,
        SEL_ID
    } reg_sel_e;

    // Identification byte for position idx counted from the first ID word.
    function automatic logic [7:0] id_value(input logic [3:0] idx);
        case (idx)
            4'd0:    id_value = 8'h04;
            4'd4:    id_value = 8'h21;
            4'd5:    id_value = 8'hB8;
            4'd6:    id_value = 8'h1B;
            4'd8:    id_value = 8'h0D;
            4'd9:    id_value = 8'hF0;
            4'd10:   id_value = 8'h05;
            4'd11:   id_value = 8'hB1;
            default: id_value = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/uart_apb_decode.sv
// Module: uart_apb_decode
// Turns an APB access into a register select, an ID word index and
// read/write strobes valid in the access phase.
// Assumes: word-aligned accesses; the low two address bits are ignored.
module uart_apb_decode
    import uart_regif_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output reg_sel_e          sel,
    output logic [3:0]        id_idx,
    output logic              wr_stb,
    output logic              rd_stb
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;

    assign word   = paddr[ADDR_W-1:2];
    assign wr_stb = psel & penable & pwrite;
    assign rd_stb = psel & penable & ~pwrite;
    assign id_idx = word[3:0] - 4'd4;

    // Map the word index onto a register select code.
    always_comb begin
        if (word == WORD_W'(WIDX_DATA))
            sel = SEL_DATA;
        else if (word == WORD_W'(WIDX_STATUS))
            sel = SEL_STATUS;
        else if (word == WORD_W'(WIDX_CONTROL))
            sel = SEL_CONTROL;
        else if (word == WORD_W'(WIDX_INTSTAT))
            sel = SEL_INTSTAT;
        else if (word == WORD_W'(WIDX_DIVISOR))
            sel = SEL_DIVISOR;
        else if (word >= WORD_W'(WIDX_ID_FIRST) && word <= WORD_W'(WIDX_ID_LAST))
            sel = SEL_ID;
        else
            sel = SEL_NONE;
    end

endmodule

// File: rtl/uart_tx_hold.sv
// Module: uart_tx_hold
// One-byte transmit holding register with full and overrun flags and a
// valid/accept handshake to the serial engine.
// Assumes: the engine asserts accept only when it can take the byte.
module uart_tx_hold #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              tx_en,
    input  logic              div_ok,
    input  logic              accept,
    input  logic              clr_ovr,
    output logic              full,
    output logic              ovr,
    output logic [BYTE_W-1:0] byte_q,
    output logic              valid,
    output logic              done
);
    assign valid = full & tx_en & div_ok;
    assign done  = valid & accept;

    // Holding byte and full flag: load when empty, release on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            full   <= 1'b0;
        end else if (load && !full) begin
            byte_q <= load_byte;
            full   <= 1'b1;
        end else if (done) begin
            full   <= 1'b0;
        end
    end

    // Overrun flag: set by a load into a full buffer, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr <= 1'b0;
        else if (load && full)
            ovr <= 1'b1;
        else if (clr_ovr)
            ovr <= 1'b0;
    end

    a_r3_overrun_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (load && full) |=> (ovr && $stable(byte_q)));

    a_r4_accept_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && accept) |=> !full);

    a_r5_hold_while_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !tx_en) |=> (full && $stable(byte_q)));

endmodule

// File: rtl/uart_rx_hold.sv
// Module: uart_rx_hold
// One-byte receive holding register with full and overrun flags.
// Assumes: rx strobe is a single-cycle pulse per byte.
module uart_rx_hold #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              rx_en,
    input  logic              take,
    input  logic              clr_ovr,
    output logic              full,
    output logic              ovr,
    output logic [BYTE_W-1:0] byte_q,
    output logic              got
);
    assign got = strobe & rx_en;

    // Store an accepted byte; a software read empties the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            full   <= 1'b0;
        end else if (got) begin
            byte_q <= in_byte;
            full   <= 1'b1;
        end else if (take) begin
            full   <= 1'b0;
        end
    end

    // Overrun flag: byte arrives into a buffer that is not being read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr <= 1'b0;
        else if (got && full && !take)
            ovr <= 1'b1;
        else if (clr_ovr)
            ovr <= 1'b0;
    end

    a_r6_drop_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !rx_en && !take) |=> ($stable(full) && $stable(byte_q)));

    a_r7_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !got) |=> !full);

endmodule

// File: rtl/uart_irq_unit.sv
// Module: uart_irq_unit
// Interrupt status: two stored event bits and two live overrun bits,
// individual interrupt lines and their OR.
// Assumes: w1c is a per-bit clear mask, nonzero only during a write.
module uart_irq_unit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_done,
    input  logic       rx_got,
    input  logic       tx_ie,
    input  logic       rx_ie,
    input  logic       txo_ie,
    input  logic       rxo_ie,
    input  logic       tx_ovr,
    input  logic       rx_ovr,
    input  logic [1:0] w1c,
    output logic [3:0] status,
    output logic       irq_tx,
    output logic       irq_rx,
    output logic       irq_tx_ovr,
    output logic       irq_rx_ovr,
    output logic       irq_any
);
    logic tx_pend;
    logic rx_pend;

    // Byte-sent event bit: set on a handshake when enabled, cleared by write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_pend <= 1'b0;
        else if (tx_done && tx_ie)
            tx_pend <= 1'b1;
        else if (w1c[0])
            tx_pend <= 1'b0;
    end

    // Byte-received event bit: set on an accepted byte when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_pend <= 1'b0;
        else if (rx_got && rx_ie)
            rx_pend <= 1'b1;
        else if (w1c[1])
            rx_pend <= 1'b0;
    end

    assign status     = {rx_ovr & rxo_ie, tx_ovr & txo_ie, rx_pend, tx_pend};
    assign irq_tx     = status[0];
    assign irq_rx     = status[1];
    assign irq_tx_ovr = status[2];
    assign irq_rx_ovr = status[3];
    assign irq_any    = |status;

    a_r4_sent_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && tx_ie) |=> irq_tx);

    a_r9_w1c_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c[0] && !(tx_done && tx_ie)) |=> !irq_tx);

    a_r9_w1c_clears_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c[1] && !(rx_got && rx_ie)) |=> !irq_rx);

endmodule

// File: rtl/uart_regif.sv
// Module: uart_regif (top)
// APB register slave for a fixed-frame UART: control and divisor registers,
// write-one-to-clear routing, read multiplexer and identification words.
// Assumes: zero-wait-state APB; serial engine attached on the line side.
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned DIV_W   = 20,
    parameter int unsigned DIV_MIN = 16,
    parameter int unsigned CTRL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_valid,
    input  logic              tx_accept,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_strobe,
    output logic [DIV_W-1:0]  baud_div,
    output logic              baud_div_ok,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_tx_ovr,
    output logic              irq_rx_ovr,
    output logic              irq_any
);
    localparam int unsigned STAT_W = 4;

    reg_sel_e          sel;
    logic [3:0]        id_idx;
    logic              wr_stb;
    logic              rd_stb;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic              tx_full, tx_ovr, tx_done;
    logic              rx_full, rx_ovr, rx_got;
    logic [BYTE_W-1:0] rx_q;
    logic [STAT_W-1:0] int_status;
    logic [STAT_W-1:0] status_word;
    logic              wr_status, wr_intstat;
    logic              clr_tx_ovr, clr_rx_ovr;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    uart_apb_decode #(.ADDR_W(ADDR_W)) u_decode (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .sel     (sel),
        .id_idx  (id_idx),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb)
    );

    assign wr_status  = wr_stb && (sel == SEL_STATUS);
    assign wr_intstat = wr_stb && (sel == SEL_INTSTAT);
    assign clr_tx_ovr = (wr_status | wr_intstat) & pwdata[SB_TX_OVR];
    assign clr_rx_ovr = (wr_status | wr_intstat) & pwdata[SB_RX_OVR];

    // Control register: keeps only its low CTRL_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_stb && sel == SEL_CONTROL)
            ctrl_q <= pwdata[CTRL_W-1:0];
    end

    // Divisor register: keeps only its low DIV_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (wr_stb && sel == SEL_DIVISOR)
            div_q <= pwdata[DIV_W-1:0];
    end

    assign baud_div    = div_q;
    assign baud_div_ok = (div_q >= DIV_W'(DIV_MIN));

    uart_tx_hold #(.BYTE_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_stb && sel == SEL_DATA),
        .load_byte (pwdata[BYTE_W-1:0]),
        .tx_en     (ctrl_q[CB_TX_EN]),
        .div_ok    (baud_div_ok),
        .accept    (tx_accept),
        .clr_ovr   (clr_tx_ovr),
        .full      (tx_full),
        .ovr       (tx_ovr),
        .byte_q    (tx_byte),
        .valid     (tx_valid),
        .done      (tx_done)
    );

    uart_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (rx_strobe),
        .in_byte (rx_byte),
        .rx_en   (ctrl_q[CB_RX_EN]),
        .take    (rd_stb && sel == SEL_DATA),
        .clr_ovr (clr_rx_ovr),
        .full    (rx_full),
        .ovr     (rx_ovr),
        .byte_q  (rx_q),
        .got     (rx_got)
    );

    uart_irq_unit u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_done    (tx_done),
        .rx_got     (rx_got),
        .tx_ie      (ctrl_q[CB_TX_IE]),
        .rx_ie      (ctrl_q[CB_RX_IE]),
        .txo_ie     (ctrl_q[CB_TXO_IE]),
        .rxo_ie     (ctrl_q[CB_RXO_IE]),
        .tx_ovr     (tx_ovr),
        .rx_ovr     (rx_ovr),
        .w1c        (wr_intstat ? pwdata[1:0] : 2'b00),
        .status     (int_status),
        .irq_tx     (irq_tx),
        .irq_rx     (irq_rx),
        .irq_tx_ovr (irq_tx_ovr),
        .irq_rx_ovr (irq_rx_ovr),
        .irq_any    (irq_any)
    );

    assign status_word = {rx_ovr, tx_ovr, rx_full, tx_full};

    // Read multiplexer: unmapped offsets return zero.
    always_comb begin
        prdata = '0;
        case (sel)
            SEL_DATA:    prdata = DATA_W'(rx_q);
            SEL_STATUS:  prdata = DATA_W'(status_word);
            SEL_CONTROL: prdata = DATA_W'(ctrl_q);
            SEL_INTSTAT: prdata = DATA_W'(int_status);
            SEL_DIVISOR: prdata = DATA_W'(div_q);
            SEL_ID:      prdata = DATA_W'(id_value(id_idx));
            default:     prdata = '0;
        endcase
    end

    a_r9_intstat_ovr_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_intstat && pwdata[SB_RX_OVR] && !rx_strobe) |=> !irq_rx_ovr);

    a_r8_status_full_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !rx_strobe && !tx_accept) |=> ($stable(tx_full) && $stable(rx_full)));

endmodule

// File: tb/uart_regif_bench.sv
// Directed bench for uart_regif: one task per scenario, each self-checking.
module uart_regif_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        tx_accept = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_strobe = 1'b0;
    logic [19:0] baud_div;
    logic        baud_div_ok;
    logic        irq_tx, irq_rx, irq_tx_ovr, irq_rx_ovr, irq_any;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    uart_regif u_uart_regif (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .tx_byte(tx_byte),
        .tx_valid(tx_valid), .tx_accept(tx_accept), .rx_byte(rx_byte),
        .rx_strobe(rx_strobe), .baud_div(baud_div), .baud_div_ok(baud_div_ok),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_tx_ovr(irq_tx_ovr),
        .irq_rx_ovr(irq_rx_ovr), .irq_any(irq_any)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        check("R13 pready", {30'd0, pready, pslverr}, 32'h2);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        apb_read(a, d);
        check(req, d, exp);
    endtask

    task automatic pulse_accept();
        @(negedge clk); tx_accept = 1'b1;
        @(negedge clk); tx_accept = 1'b0;
    endtask

    task automatic pulse_rx(input logic [7:0] b);
        @(negedge clk); rx_byte = b; rx_strobe = 1'b1;
        @(negedge clk); rx_strobe = 1'b0;
    endtask

    // R1: reset values of all registers and outputs.
    task automatic t_reset();
        read_check("R1 status", 12'h004, 32'h0);
        read_check("R1 control", 12'h008, 32'h0);
        read_check("R1 intstat", 12'h00C, 32'h0);
        read_check("R1 divisor", 12'h010, 32'h0);
        read_check("R1 data", 12'h000, 32'h0);
        check("R1 tx_valid/irq_any", {30'd0, tx_valid, irq_any}, 32'h0);
    endtask

    // R11: register widths and divisor validity flag.
    task automatic t_widths();
        apb_write(12'h008, 32'hFFFF_FFFF);
        read_check("R11 control width", 12'h008, 32'h7F);
        apb_write(12'h008, 32'h0);
        apb_write(12'h010, 32'hFFFF_FFFF);
        read_check("R11 divisor width", 12'h010, 32'hFFFFF);
        apb_write(12'h010, 32'd15);
        check("R11 div 15 invalid", {31'd0, baud_div_ok}, 32'h0);
    endtask

    // R2-R5, R9, R10: transmit path and its interrupts.
    task automatic t_transmit();
        apb_write(12'h008, 32'h05);
        apb_write(12'h000, 32'hA5);
        read_check("R2 tx full set", 12'h004, 32'h1);
        check("R5 no valid with bad divisor", {31'd0, tx_valid}, 32'h0);
        apb_write(12'h010, 32'd16);
        check("R2 tx_valid", {31'd0, tx_valid}, 32'h1);
        check("R2 tx_byte", {24'd0, tx_byte}, 32'hA5);
        apb_write(12'h008, 32'h04);
        check("R5 valid drops with enable", {31'd0, tx_valid}, 32'h0);
        read_check("R5 byte still held", 12'h004, 32'h1);
        apb_write(12'h008, 32'h05);
        apb_write(12'h000, 32'h3C);
        read_check("R3 overrun flag", 12'h004, 32'h5);
        check("R3 byte unchanged", {24'd0, tx_byte}, 32'hA5);
        pulse_accept();
        read_check("R4 full cleared", 12'h004, 32'h4);
        read_check("R9 ovr masked", 12'h00C, 32'h1);
        check("R10 irq_tx/any", {30'd0, irq_tx, irq_any}, 32'h3);
        apb_write(12'h008, 32'h15);
        read_check("R9 tx ovr live", 12'h00C, 32'h5);
        check("R10 irq_tx_ovr", {31'd0, irq_tx_ovr}, 32'h1);
        apb_write(12'h00C, 32'h4);
        read_check("R9 intstat clears flag", 12'h004, 32'h0);
        read_check("R9 tx bit kept", 12'h00C, 32'h1);
        apb_write(12'h00C, 32'h1);
        check("R10 irq_any low", {31'd0, irq_any}, 32'h0);
        apb_write(12'h008, 32'h01);
        apb_write(12'h000, 32'h11);
        check("R2 second byte", {24'd0, tx_byte}, 32'h11);
        pulse_accept();
        read_check("R4 no irq when disabled", 12'h00C, 32'h0);
    endtask

    // R6-R8, R10: receive path, overrun and status write-one-to-clear.
    task automatic t_receive();
        apb_write(12'h008, 32'h00);
        pulse_rx(8'h55);
        read_check("R6 dropped status", 12'h004, 32'h0);
        read_check("R6 dropped data", 12'h000, 32'h0);
        apb_write(12'h008, 32'h0A);
        pulse_rx(8'h66);
        read_check("R6 rx full", 12'h004, 32'h2);
        read_check("R6 rx int", 12'h00C, 32'h2);
        check("R10 irq_rx", {31'd0, irq_rx}, 32'h1);
        pulse_rx(8'h77);
        read_check("R6 rx overrun", 12'h004, 32'hA);
        apb_write(12'h008, 32'h2A);
        check("R10 irq_rx_ovr", {31'd0, irq_rx_ovr}, 32'h1);
        apb_write(12'h004, 32'h3);
        read_check("R8 ro bits ignore", 12'h004, 32'hA);
        apb_write(12'h004, 32'h8);
        read_check("R8 w1c overrun", 12'h004, 32'h2);
        check("R10 irq_rx_ovr low", {31'd0, irq_rx_ovr}, 32'h0);
        read_check("R7 data is newest", 12'h000, 32'h77);
        read_check("R7 full cleared", 12'h004, 32'h0);
        apb_write(12'h00C, 32'h2);
        read_check("R9 rx bit cleared", 12'h00C, 32'h0);
    endtask

    // R12: identification words and their write protection.
    task automatic t_ids();
        logic [7:0] ids [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h21, 8'hB8,
                                 8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 12; i++)
            read_check("R12 id word", 12'hFD0 + 12'(i * 4), {24'd0, ids[i]});
        apb_write(12'hFD0, 32'hFF);
        read_check("R12 id write ignored", 12'hFD0, 32'h04);
    endtask

    // R13: unmapped offsets.
    task automatic t_unmapped();
        apb_write(12'h008, 32'h03);
        apb_write(12'h014, 32'hFF);
        read_check("R13 unmapped reads zero", 12'h014, 32'h0);
        read_check("R13 mid window zero", 12'h800, 32'h0);
        read_check("R13 control untouched", 12'h008, 32'h03);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_widths();
        t_transmit();
        t_receive();
        t_ids();
        t_unmapped();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule